// File: doc/BRIEF.md
# Single-Wire Pulse-Count Voltage Programmer

This block turns one raw control line into an enable level and a 6-bit voltage code for a negative supply regulator. The line is first brought into the clock domain by a synchronizer, and only the synchronized level is decoded. A rising edge while the block is idle enables it with code zero. Each later rising edge moves the code up by one step. The code stops at 41.

The code maps to a signed setpoint in millivolts. Code zero is a default of −4000 mV, which lies in the middle of the range, so the map is not monotonic. Codes 1 to 41 run linearly from −5400 mV to −1400 mV in 100 mV steps. A low interval shorter than a programmable timeout counts as part of a programming pulse. A low interval that reaches the timeout disables the block and clears the code. The default timeout is 25000 clock cycles, which is 200 µs at 125 MHz.

Top module: `pulse_vprog`

## Requirements
- R1: After reset, `en` is 0, `code` is 0 and `setpoint_mv` is −4000.
- R2: A rising edge of the synchronized line while `en` is 0 sets `en` to 1 and loads `code` 0. If `ctrl_raw` takes its new level before clock edge e0, the outputs change at edge e0+2.
- R3: While `en` is 1, each rising edge of the synchronized line adds one to `code`, with the same latency as in R2. Between edges, `en` and `code` hold their values.
- R4: `code` saturates at 41. Rising edges that arrive while `code` is 41 leave it at 41.
- R5: `setpoint_mv` is a signed 16-bit value taken from `code` in the same cycle. Code 0 gives −4000, and code n for n from 1 to 41 gives −5400 + 100·(n−1). So code 1 is −5400, code 15 is −4000 and code 41 is −1400.
- R6: Suppose the synchronized line stays low for LOW_TICKS consecutive cycles. Then `en` and `code` are cleared at the clock edge that ends the LOW_TICKS-th low cycle. A low interval of LOW_TICKS−1 cycles or fewer keeps `en` at 1, and the rising edge that follows counts as a step.
- R7: After a timeout, the next rising edge enables the block again with `code` 0, whatever the code was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_raw | input | 1 | Raw, unsynchronized enable/programming line |
| en | output | 1 | Enable level for the regulator |
| code | output | 6 | Selected voltage code |
| setpoint_mv | output | 16 | Signed setpoint in millivolts |

## Verification
The bench drives `ctrl_raw` on falling edges. It expects `en` and `code` to change at the third rising edge that samples the new level: the first and second edges fill the synchronizer, and the third loads the state. `setpoint_mv` follows `code` in the same cycle. A behavioural model keeps the history of sampled inputs in a queue and reads the value from two edges back. It counts the length of each low run as an integer, and it is compared with the outputs at every falling edge. The directed checks sample at least four cycles after each high phase begins, which is after the update has landed. The timeout is checked with low intervals of exactly LOW_TICKS−1 cycles and exactly LOW_TICKS cycles, to catch off-by-one errors in either direction.

// File: rtl/pvp_pkg.sv
package pvp_pkg;

    parameter int CODE_W     = 6;
    parameter int MV_W       = 16;
    parameter int MAX_CODE   = 41;
    parameter int DEFAULT_MV = -4000;
    parameter int BASE_MV    = -5400;
    parameter int STEP_MV    = 100;

    typedef logic [CODE_W-1:0]      code_t;
    typedef logic signed [MV_W-1:0] mv_t;

    typedef struct packed {
        logic  en;
        code_t code;
    } prog_state_t;

    // Non-monotonic map: zero is the mid-range default, 1..MAX_CODE is linear.
    function automatic mv_t code_to_mv(input code_t c);
        int v;
        if (c == '0) v = DEFAULT_MV;
        else         v = BASE_MV + (int'(c) - 1) * STEP_MV;
        return mv_t'(v);
    endfunction

endpackage

// File: rtl/pvp_sync.sv
module pvp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain   <= '0;
            level_d <= 1'b0;
        end else begin
            chain   <= {chain[STAGES-2:0], din};
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~level_d;

endmodule

// File: rtl/pvp_low_timer.sv
module pvp_low_timer #(
    parameter int LOW_TICKS = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic expire
);
    localparam int CNT_W = $clog2(LOW_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOW_TICKS - 1);

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || level)        low_cnt <= '0;
        else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
    end

    assign expire = ~level && (low_cnt == LIMIT);

    AST_LOW_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LIMIT);                                            // R6
    AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        level |=> (low_cnt == '0));                                   // R6

endmodule

// File: rtl/pvp_counter.sv
module pvp_counter
    import pvp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rise,
    input  logic        expire,
    output prog_state_t st
);
    localparam code_t TOP = code_t'(MAX_CODE);

    prog_state_t st_n;

    always_comb begin
        st_n = st;
        if (expire) begin
            st_n.en   = 1'b0;
            st_n.code = '0;
        end else if (rise) begin
            if (!st.en) begin
                st_n.en   = 1'b1;
                st_n.code = '0;
            end else if (st.code != TOP) begin
                st_n.code = st.code + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    AST_ENABLE_LOADS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rise && !st.en) |=> (st.en && st.code == '0));               // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (rise && st.en && st.code != TOP) |=> (st.code == code_t'($past(st.code) + 1'b1))); // R3
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rise && !expire) |=> ($stable(st.code) && $stable(st.en))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st.code <= TOP);                                              // R4
    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (rise && st.en && st.code == TOP) |=> (st.code == TOP));      // R4
    AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        expire |=> (!st.en && st.code == '0));                        // R6

endmodule

// File: rtl/pvp_setpoint.sv
module pvp_setpoint
    import pvp_pkg::*;
(
    input  code_t code,
    output mv_t   mv
);
    assign mv = code_to_mv(code);
endmodule

// File: rtl/pulse_vprog.sv
module pulse_vprog
    import pvp_pkg::*;
#(
    parameter int LOW_TICKS   = 25000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_raw,
    output logic              en,
    output logic [CODE_W-1:0] code,
    output logic [MV_W-1:0]   setpoint_mv
);
    logic        lvl, rise, expire;
    prog_state_t st;
    mv_t         mv;

    pvp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(ctrl_raw), .level(lvl), .rise(rise)
    );

    pvp_low_timer #(.LOW_TICKS(LOW_TICKS)) u_timer (
        .clk(clk), .rst(rst), .level(lvl), .expire(expire)
    );

    pvp_counter u_cnt (
        .clk(clk), .rst(rst), .rise(rise), .expire(expire), .st(st)
    );

    pvp_setpoint u_map (
        .code(st.code), .mv(mv)
    );

    assign en          = st.en;
    assign code        = st.code;
    assign setpoint_mv = mv;

    AST_MV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mv >= mv_t'(BASE_MV)) && (mv <= mv_t'(BASE_MV + (MAX_CODE - 1) * STEP_MV))); // R5
    AST_MV_STEP: assert property (@(posedge clk) disable iff (rst)
        (code != '0 && code == code_t'($past(code) + 1'b1) && $past(code) != '0)
        |-> (int'(mv) == int'($past(mv)) + STEP_MV));                 // R5

endmodule

// File: tb/sim_pulse_vprog.sv
module sim_pulse_vprog;
    localparam int T = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_raw = 1'b0;
    logic        en;
    logic [5:0]  code;
    logic [15:0] setpoint_mv;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    pulse_vprog #(.LOW_TICKS(T)) u0 (
        .clk(clk), .rst(rst), .ctrl_raw(ctrl_raw),
        .en(en), .code(code), .setpoint_mv(setpoint_mv)
    );

    always #4 clk = ~clk;

    // Behavioural reference model
    bit   hist[$];
    int   low_run = 0;
    bit   m_en = 0;
    int   m_code = 0;

    function automatic int exp_mv(int c);
        if (c == 0) return -4000;
        return -5400 + 100 * (c - 1);
    endfunction

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            hist.delete();
            low_run = 0;
            m_en = 0;
            m_code = 0;
        end else begin
            bit s, p;
            hist.push_back(ctrl_raw);
            s = (hist.size() >= 3) ? hist[hist.size()-3] : 1'b0;
            p = (hist.size() >= 4) ? hist[hist.size()-4] : 1'b0;
            if (s) low_run = 0; else low_run++;
            if (!s && low_run >= T) begin
                m_en = 0; m_code = 0;
            end else if (s && !p) begin
                if (!m_en) begin m_en = 1; m_code = 0; end
                else if (m_code < 41) m_code++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2/R6 en vs model", int'(en), int'(m_en));
            check("R3/R4 code vs model", int'(code), m_code);
            check("R5 setpoint vs model", int'($signed(setpoint_mv)), exp_mv(m_code));
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_low_high(int low_len, int high_len);
        ctrl_raw = 1'b0; wait_cyc(low_len);
        ctrl_raw = 1'b1; wait_cyc(high_len);
    endtask

    task automatic disable_long();
        ctrl_raw = 1'b0; wait_cyc(T + 10);
        check("R6 long low clears en", int'(en), 0);
        check("R6 long low clears code", int'(code), 0);
        check("R6 long low default setpoint", int'($signed(setpoint_mv)), -4000);
    endtask

    task automatic burst(int n);
        disable_long();
        ctrl_raw = 1'b1; wait_cyc(4);
        check("R7 enable en", int'(en), 1);
        check("R7 enable code", int'(code), 0);
        for (int k = 1; k <= n; k++) begin
            int e;
            pulse_low_high(4, 4);
            e = (k > 41) ? 41 : k;
            check((k > 41) ? "R4 saturated code" : "R3 stepped code", int'(code), e);
            check("R5 setpoint", int'($signed(setpoint_mv)), exp_mv(e));
        end
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 reset en", int'(en), 0);
        check("R1 reset code", int'(code), 0);
        check("R1 reset setpoint", int'($signed(setpoint_mv)), -4000);

        // R2 latency: raw rises before e0; no change after e0,e1; change at e2
        ctrl_raw = 1'b1;
        wait_cyc(2);
        check("R2 not yet enabled", int'(en), 0);
        wait_cyc(1);
        check("R2 enabled at third edge", int'(en), 1);
        check("R2 code zero", int'(code), 0);
        wait_cyc(4);

        burst(1);
        burst(3);
        check("R5 code 3 is -5200", int'($signed(setpoint_mv)), -5200);
        burst(15);
        check("R5 code 15 is -4000", int'($signed(setpoint_mv)), -4000);
        burst(41);
        check("R5 code 41 is -1400", int'($signed(setpoint_mv)), -1400);
        burst(45);
        check("R4 code held at 41", int'(code), 41);

        // R6 boundary: T-1 low cycles still a step, T low cycles disable
        burst(2);
        pulse_low_high(T - 1, 6);
        check("R6 short low keeps en", int'(en), 1);
        check("R6 short low steps code", int'(code), 3);
        pulse_low_high(T, 6);
        check("R7 re-enable after exact timeout en", int'(en), 1);
        check("R7 re-enable after exact timeout code", int'(code), 0);

        disable_long();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule